// File: doc/BRIEF.md
# Audio DMA Sample Frame Counter

This block tracks the memory position and the sample countdown of a single audio DMA channel. Software programs a buffer base address, a frame register holding the current dword position together with the buffer size, a sample-count register holding the remaining samples in the current block together with the block reload value, and a configuration word. The configuration word selects the sample format, the end-of-buffer behaviour and whether the channel runs. For every transfer step it accepts, the block presents the byte address that the data mover should access. It flags the step that completes a block and then advances its position by one sample.

Steps arrive on a valid/ready handshake. A step is taken in a cycle where `step_valid` and `step_ready` are both high. `step_ready` is low while the channel is not running, while the channel has stopped at the end of its buffer, and in any cycle that carries a register write. The upstream side may hold `step_valid` high for any number of cycles. `xfer_addr` always shows the address of the next step. `xfer_eob` is high only in a cycle where a step is taken and that step ends a block. The data mover and the format conversion sit outside this block.

Top module: `audio_dma_frame_counter`

## Requirements
- R1: After reset, every register reads as zero and `step_ready` is low.
- R2: The register port uses byte offsets. Offset 0x0 is the base address. Offset 0x4 is the frame register: the current dword index is in bits 31:16 and the buffer size in dwords minus one is in bits 15:0. Offset 0x8 is the sample-count register: the remaining samples minus one are in bits 31:16 and the reload value (samples per block minus one) is in bits 15:0. Offset 0xC is the configuration word: bit 0 is run, bits 2:1 are the format, and bit 3 is the stop-at-end select. A wide access (`reg_wide`=1) writes or reads all 32 bits.
- R3: A narrow access (`reg_wide`=0) addresses the 16-bit half chosen by offset bit 1 (+0 for the low half, +2 for the high half). It writes `reg_wdata[15:0]` into that half only, and reads that half zero-extended. A narrow write at +0 of the sample-count register changes only the reload value. A narrow read at +2 of the frame register returns the current index.
- R4: Bytes per sample equal 1 << (fmt[0] + fmt[1]), where fmt[0] selects stereo and fmt[1] selects 16-bit. Format codes 0, 1, 2 and 3 therefore step by 1, 2, 2 and 4 bytes.
- R5: `xfer_addr` equals base + 4 × current index + the 2-bit byte leftover.
- R6: Each taken step adds the sample size to the leftover modulo 4. A carry out of the leftover advances the dword index by one.
- R7: A taken step with remaining count zero raises `xfer_eob` and reloads the remaining count from the reload value. Any other taken step decrements the remaining count by one.
- R8: With stop-at-end at 0 (loop mode), a dword carry out of the last index (index equal to size) wraps the index to 0.
- R9: With stop-at-end at 1, a dword carry out of the last index leaves the index at the last dword and stops the channel: `step_ready` stays low until the frame register is written. Any write to the frame register also clears the leftover.
- R10: While run is 0, `step_ready` is low, `step_valid` has no effect, and the index, leftover and counts hold their values until run is set again.
- R11: `step_ready` is low in every cycle where `reg_we` is high, so a register write and a step never land together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_wide | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Write data (16-bit writes use bits 15:0) |
| reg_rdata | output | 32 | Read data for `reg_addr`/`reg_wide` |
| step_valid | input | 1 | Upstream offers a transfer step |
| step_ready | output | 1 | Block can take a step this cycle |
| xfer_addr | output | 32 | Byte address of the next step |
| xfer_eob | output | 1 | Taken step completes a block |

## Verification
Every cycle, the embedded assertions check that the position, leftover and counts stay frozen while the channel is idle. They also check that the remaining count reloads on a block end and that the index either wraps or freezes with the stopped flag at the buffer end. Finally, they check that `step_ready` is never offered while stopped or during a register write. Only the bench's sweeps over format, size, reload and end mode can show that the address sequence and the block-end pattern add up to the right arithmetic across a whole buffer. The same is true of the half-register access rules and of a clean resume after the channel is paused.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  localparam int HALF_W = 16;

  typedef enum logic [1:0] {
    SEL_BASE  = 2'd0,
    SEL_FRAME = 2'd1,
    SEL_COUNT = 2'd2,
    SEL_CFG   = 2'd3
  } reg_sel_e;

  // bytes per sample: 1 << (stereo + wide)
  function automatic logic [2:0] sample_bytes(input logic [1:0] fmt);
    logic [1:0] sh;
    sh = 2'(fmt[0]) + 2'(fmt[1]);
    return 3'd1 << sh;
  endfunction
endpackage

// File: rtl/sfc_frame_pos.sv
module sfc_frame_pos #(
  parameter int HW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [HW-1:0] wr_lo_val,
  input  logic [HW-1:0] wr_hi_val,
  input  logic          step_fire,
  input  logic [2:0]    step_bytes,
  input  logic          stop_mode,
  output logic [HW-1:0] idx,
  output logic [HW-1:0] size,
  output logic [1:0]    leftover,
  output logic          done
);
  logic [2:0] sum;
  logic       carry;
  logic       at_last;

  assign sum     = 3'({1'b0, leftover}) + step_bytes;
  assign carry   = sum[2];
  assign at_last = (idx == size);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx      <= '0;
      size     <= '0;
      leftover <= '0;
      done     <= 1'b0;
    end else if (wr_lo || wr_hi) begin
      if (wr_lo) size <= wr_lo_val;
      if (wr_hi) idx  <= wr_hi_val;
      leftover <= '0;
      done     <= 1'b0;
    end else if (step_fire) begin
      leftover <= sum[1:0];
      if (carry) begin
        if (!at_last)       idx  <= idx + 1'b1;
        else if (stop_mode) done <= 1'b1;
        else                idx  <= '0;
      end
    end
  end

  // R6: a step that produces no dword carry leaves the index where it was
  a_r6_no_carry_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && !wr_lo && !wr_hi && !carry) |=> $stable(idx));

  // R8: loop mode wraps to dword zero after the last dword
  a_r8_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && !wr_lo && !wr_hi && carry && at_last && !stop_mode) |=> (idx == '0));

  // R9: stop mode freezes the index and raises the stopped flag
  a_r9_stop_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && !wr_lo && !wr_hi && carry && at_last && stop_mode) |=> (done && $stable(idx)));
endmodule

// File: rtl/sfc_sample_count.sv
module sfc_sample_count #(
  parameter int HW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [HW-1:0] wr_lo_val,
  input  logic [HW-1:0] wr_hi_val,
  input  logic          step_fire,
  output logic [HW-1:0] remain,
  output logic [HW-1:0] reload,
  output logic          eob
);
  logic expire;
  assign expire = (remain == '0);
  assign eob    = step_fire && expire;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain <= '0;
      reload <= '0;
    end else if (wr_lo || wr_hi) begin
      if (wr_lo) reload <= wr_lo_val;
      if (wr_hi) remain <= wr_hi_val;
    end else if (step_fire) begin
      remain <= expire ? reload : remain - 1'b1;
    end
  end

  // R7: block end reloads the countdown from the reload half
  a_r7_reload_on_end: assert property (@(posedge clk) disable iff (!rst_n)
    (eob && !wr_lo && !wr_hi) |=> (remain == $past(reload)));

  // R3: a write to the reload half alone keeps the running count
  a_r3_reload_write_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !wr_hi) |=> $stable(remain));
endmodule

// File: rtl/audio_dma_frame_counter.sv
module audio_dma_frame_counter #(
  parameter int HW = sfc_pkg::HALF_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic            reg_wide,
  input  logic [3:0]      reg_addr,
  input  logic [2*HW-1:0] reg_wdata,
  output logic [2*HW-1:0] reg_rdata,
  input  logic            step_valid,
  output logic            step_ready,
  output logic [2*HW-1:0] xfer_addr,
  output logic            xfer_eob
);
  import sfc_pkg::*;
  localparam int DW = 2 * HW;

  logic [DW-1:0] base_q;
  logic          run_q;
  logic [1:0]    fmt_q;
  logic          stop_q;

  reg_sel_e      sel;
  logic          lo_en, hi_en;
  logic [HW-1:0] lo_val, hi_val;
  logic          fr_lo, fr_hi, ct_lo, ct_hi;

  logic [HW-1:0] idx, size, remain, reload;
  logic [1:0]    leftover;
  logic          done;
  logic          step_fire;
  logic [2:0]    bytes;

  assign sel    = reg_sel_e'(reg_addr[3:2]);
  assign lo_en  = reg_we && (reg_wide || !reg_addr[1]);
  assign hi_en  = reg_we && (reg_wide ||  reg_addr[1]);
  assign lo_val = reg_wdata[HW-1:0];
  assign hi_val = reg_wide ? reg_wdata[DW-1:HW] : reg_wdata[HW-1:0];
  assign fr_lo  = lo_en && (sel == SEL_FRAME);
  assign fr_hi  = hi_en && (sel == SEL_FRAME);
  assign ct_lo  = lo_en && (sel == SEL_COUNT);
  assign ct_hi  = hi_en && (sel == SEL_COUNT);

  assign step_ready = run_q && !done && !reg_we;
  assign step_fire  = step_valid && step_ready;
  assign bytes      = sample_bytes(fmt_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      run_q  <= 1'b0;
      fmt_q  <= '0;
      stop_q <= 1'b0;
    end else begin
      if (lo_en && sel == SEL_BASE) base_q[HW-1:0]  <= lo_val;
      if (hi_en && sel == SEL_BASE) base_q[DW-1:HW] <= hi_val;
      if (lo_en && sel == SEL_CFG) begin
        run_q  <= lo_val[0];
        fmt_q  <= lo_val[2:1];
        stop_q <= lo_val[3];
      end
    end
  end

  sfc_frame_pos #(.HW(HW)) u_pos (
    .clk(clk), .rst_n(rst_n),
    .wr_lo(fr_lo), .wr_hi(fr_hi), .wr_lo_val(lo_val), .wr_hi_val(hi_val),
    .step_fire(step_fire), .step_bytes(bytes), .stop_mode(stop_q),
    .idx(idx), .size(size), .leftover(leftover), .done(done)
  );

  sfc_sample_count #(.HW(HW)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .wr_lo(ct_lo), .wr_hi(ct_hi), .wr_lo_val(lo_val), .wr_hi_val(hi_val),
    .step_fire(step_fire),
    .remain(remain), .reload(reload), .eob(xfer_eob)
  );

  assign xfer_addr = base_q + DW'({idx, 2'b00}) + DW'(leftover);

  logic [DW-1:0] word;
  always_comb begin
    unique case (sel)
      SEL_BASE:  word = base_q;
      SEL_FRAME: word = {idx, size};
      SEL_COUNT: word = {remain, reload};
      default:   word = DW'({stop_q, fmt_q, run_q});
    endcase
    if (reg_wide)         reg_rdata = word;
    else if (reg_addr[1]) reg_rdata = {{HW{1'b0}}, word[DW-1:HW]};
    else                  reg_rdata = {{HW{1'b0}}, word[HW-1:0]};
  end

  // R10: an idle channel keeps position and counts
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !reg_we) |=> ($stable(idx) && $stable(leftover) && $stable(remain)));

  // R9: a stopped channel never offers a step
  a_r9_stopped_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !step_ready);

  // R11: register writes and steps never share a cycle
  a_r11_write_blocks_step: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> !step_ready);

  // R7: block-end flag only accompanies a taken step
  a_r7_eob_with_step: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_eob |-> (step_valid && step_ready));
endmodule

// File: tb/audio_dma_frame_counter_test.sv
module audio_dma_frame_counter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic        reg_wide = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        step_valid = 1'b0;
  logic        step_ready;
  logic [31:0] xfer_addr;
  logic        xfer_eob;

  int compared = 0;
  int mismatched = 0;
  bit wd_hit = 0;

  // bench model of channel state
  int m_base, m_idx, m_size, m_left, m_rem, m_rel, m_fmt, m_stop;
  bit m_done;

  always #10 clk = ~clk;

  audio_dma_frame_counter uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wide(reg_wide),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .step_valid(step_valid), .step_ready(step_ready),
    .xfer_addr(xfer_addr), .xfer_eob(xfer_eob)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input bit wide, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_wide = wide; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1 reg_we = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [3:0] a, input bit wide, input logic [31:0] exp);
    @(negedge clk);
    reg_wide = wide; reg_addr = a;
    #1 chk(tag, reg_rdata, exp);
  endtask

  function automatic int nbytes(input int fmt);
    return 1 << ((fmt & 1) + ((fmt >> 1) & 1));
  endfunction

  // one offered step, checked against the model, then model update
  task automatic step_once();
    int s;
    @(negedge clk);
    step_valid = 1'b1;
    #1;
    if (m_done) begin
      chk("R9 ready low when stopped", {31'b0, step_ready}, 32'd0);
      @(posedge clk);
      #1 step_valid = 1'b0;
      return;
    end
    chk("R10 ready while running", {31'b0, step_ready}, 32'd1);
    chk("R5 R4 R6 xfer_addr", xfer_addr, 32'(m_base + 4 * m_idx + m_left));
    chk("R7 xfer_eob", {31'b0, xfer_eob}, {31'b0, m_rem == 0});
    @(posedge clk);
    #1 step_valid = 1'b0;
    m_rem = (m_rem == 0) ? m_rel : m_rem - 1;
    s = m_left + nbytes(m_fmt);
    m_left = s % 4;
    if (s >= 4) begin
      if (m_idx != m_size)  m_idx++;
      else if (m_stop != 0) m_done = 1;
      else                  m_idx = 0;
    end
  endtask

  task automatic setup(input int base, input int fmt, input int stop, input int size, input int rel);
    m_base = base; m_fmt = fmt; m_stop = stop; m_size = size;
    m_rel = rel; m_rem = rel; m_idx = 0; m_left = 0; m_done = 0;
    wr(4'h0, 1, 32'(base));
    wr(4'h8, 1, {16'(rel), 16'(rel)});
    wr(4'h4, 1, {16'd0, 16'(size)});
    wr(4'hC, 1, 32'(1 | (fmt << 1) | (stop << 3)));
  endtask

  task automatic run_all();
    // R1: reset state
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    rd("R1 base reset", 4'h0, 1, 32'd0);
    rd("R1 frame reset", 4'h4, 1, 32'd0);
    rd("R1 count reset", 4'h8, 1, 32'd0);
    rd("R1 cfg reset", 4'hC, 1, 32'd0);
    @(negedge clk); step_valid = 1'b1;
    #1 chk("R1 ready after reset", {31'b0, step_ready}, 32'd0);
    step_valid = 1'b0;

    // R2: wide write/read of every register
    wr(4'h0, 1, 32'hCAFE_0010);
    rd("R2 base wide", 4'h0, 1, 32'hCAFE_0010);
    wr(4'h4, 1, 32'h0003_0007);
    rd("R2 frame wide", 4'h4, 1, 32'h0003_0007);
    wr(4'hC, 1, 32'h0000_000A);
    rd("R2 cfg wide", 4'hC, 1, 32'h0000_000A);

    // R3: half access rules
    wr(4'h8, 1, 32'h0005_0009);
    wr(4'h8, 0, 32'h0000_0002);
    rd("R3 narrow reload write keeps count", 4'h8, 1, 32'h0005_0002);
    wr(4'hA, 0, 32'h0000_0004);
    rd("R3 narrow high write", 4'h8, 1, 32'h0004_0002);
    rd("R3 frame +2 returns index", 4'h6, 0, 32'h0000_0003);
    rd("R3 frame +0 returns size", 4'h4, 0, 32'h0000_0007);

    // sweep: format x end mode x size x reload (R4..R9)
    for (int fmt = 0; fmt < 4; fmt++)
      for (int stop = 0; stop < 2; stop++)
        for (int size = 0; size < 3; size++)
          for (int rel = 0; rel < 3; rel += 2) begin
            int nsteps;
            setup(32'h1000 + 32'h100 * fmt + 32'h40 * size, fmt, stop, size, rel);
            nsteps = ((size + 1) * 4) / nbytes(fmt) + 3;
            for (int k = 0; k < nsteps; k++) step_once();
            rd("R8 R9 index after sweep", 4'h6, 0, 32'(m_idx));
            rd("R7 remaining after sweep", 4'hA, 0, 32'(m_rem));
          end

    // R9: frame write restarts a stopped channel
    setup(32'h2000, 3, 1, 0, 0);
    step_once(); step_once();
    rd("R9 index held at last dword", 4'h4, 1, 32'h0000_0000);
    wr(4'h4, 1, 32'h0000_0001);
    m_idx = 0; m_size = 1; m_left = 0; m_done = 0;
    step_once();
    rd("R9 restart advanced index", 4'h6, 0, 32'd1);

    // R10: pause holds state; resume continues
    setup(32'h3000, 1, 0, 3, 2);
    step_once(); step_once(); step_once();
    wr(4'hC, 1, 32'h0000_0002);
    @(negedge clk); step_valid = 1'b1;
    #1 chk("R10 ready low when idle", {31'b0, step_ready}, 32'd0);
    repeat (3) @(posedge clk);
    #1 step_valid = 1'b0;
    rd("R10 frame held", 4'h4, 1, {16'(m_idx), 16'(m_size)});
    rd("R10 count held", 4'h8, 1, {16'(m_rem), 16'(m_rel)});
    wr(4'hC, 1, 32'h0000_0003);
    step_once(); step_once();

    // R11: no step during a register write
    @(negedge clk);
    step_valid = 1'b1; reg_we = 1'b1; reg_wide = 1'b1; reg_addr = 4'h0; reg_wdata = 32'h3000;
    #1 chk("R11 ready low during write", {31'b0, step_ready}, 32'd0);
    @(posedge clk);
    #1 begin reg_we = 1'b0; step_valid = 1'b0; end
    rd("R11 index unchanged by write cycle", 4'h6, 0, 32'(m_idx));
  endtask

  initial begin
    fork
      run_all();
      begin #(20 * 150000); wd_hit = 1; end
    join_any
    if (wd_hit) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule